// File: doc/BRIEF.md
# Keyed Timer Write Enable

This block protects the timekeeping registers of a real-time clock from stray writes. Software has to write a fixed two-byte key to a dedicated unlock register before it can raise the write-enable bit. The block watches every byte written to that register, and it accepts a request to set the enable only in the single cycle that follows the second key byte.

While the enable is high, the block passes through requests to write timer fields. While it is low, it drops them. Software lowers the enable directly, and it needs no key to do so. The counters themselves and the register addressing sit outside this block. They consume the grant that this block produces.

The key bytes are parameters. By default they are 0x55 followed by 0xAA.

Top module: `unlock_wen_gate`

## Requirements
- R1: After reset `wr_permit` is 0, and no set request succeeds until a full key has been written.
- R2: After an unlock write of KEY_A (0x55) followed by an unlock write of KEY_B (0xAA), a `wen_set` pulse in the cycle right after the KEY_B write makes `wr_permit` 1 from the next clock edge.
- R3: A `wen_set` at any other time leaves `wr_permit` unchanged. This covers a set in the same cycle as the KEY_B write, a set one or more cycles late, and a set with no key at all.
- R4: An unlock write of any byte other than the expected key byte returns the detector to idle, so a later KEY_B does not open the window.
- R5: Cycles with no unlock write between KEY_A and KEY_B do not disturb the detector.
- R6: `wen_clr` clears `wr_permit` at the next edge at any time, with no key needed.
- R7: When `wen_clr` and a valid `wen_set` arrive in the same window cycle, the clear wins and `wr_permit` ends 0.
- R8: `fld_wr_gnt` equals `fld_wr_req` AND `wr_permit` in every cycle.
- R9: Repeated KEY_A writes keep the detector waiting for KEY_B, so the sequence KEY_A, KEY_A, KEY_B still opens the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| unlk_wr | input | 1 | Byte write strobe to the unlock register |
| unlk_data | input | 8 | Byte written to the unlock register |
| wen_set | input | 1 | Request to raise the write enable |
| wen_clr | input | 1 | Request to lower the write enable |
| fld_wr_req | input | 1 | Timer field write request from the register port |
| wr_permit | output | 1 | Current write-enable state |
| fld_wr_gnt | output | 1 | Timer field write allowed this cycle |

## Verification
Suppose the key detector holds a wrong state, for example it forgets KEY_A or it keeps the window open. That fault appears only as a wrong `wr_permit` one edge after a set request. The stimulus therefore probes the set at each position around the key: too early, exactly on time and late. It also sends broken, padded and repeated keys. The window has to close again after one cycle, so a second set placed one cycle late shows a window that stays open.

// File: rtl/unlock_wen_pkg.sv
package unlock_wen_pkg;
    typedef enum logic [0:0] {
        KS_IDLE  = 1'b0,
        KS_FIRST = 1'b1
    } key_state_e;
endpackage

// File: rtl/wen_key_detect.sv
module wen_key_detect
    import unlock_wen_pkg::*;
#(
    parameter int            DATA_W = 8,
    parameter logic [DATA_W-1:0] KEY_A = 8'h55,
    parameter logic [DATA_W-1:0] KEY_B = 8'hAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] data,
    output logic              key_done
);
    typedef struct packed {
        key_state_e st;
    } kd_state_t;

    kd_state_t s_d, s_q;
    logic      done_c;

    always_comb begin
        s_d    = s_q;
        done_c = 1'b0;
        if (wr) begin
            if (s_q.st == KS_FIRST && data == KEY_B) begin
                done_c  = 1'b1;
                s_d.st  = KS_IDLE;
            end else if (data == KEY_A) begin
                s_d.st  = KS_FIRST;
            end else begin
                s_d.st  = KS_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: KS_IDLE};
        else        s_q <= s_d;
    end

    assign key_done = done_c;

    AST_DONE_NEEDS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        key_done |-> (s_q.st == KS_FIRST && wr)); // R4
    AST_DONE_RETURNS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        key_done |=> (s_q.st == KS_IDLE)); // R3
endmodule

// File: rtl/wen_arm_window.sv
module wen_arm_window (
    input  logic clk,
    input  logic rst_n,
    input  logic key_done,
    output logic arm
);
    typedef struct packed {
        logic arm;
    } aw_state_t;

    aw_state_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.arm = key_done;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{arm: 1'b0};
        else        s_q <= s_d;
    end

    assign arm = s_q.arm;

    AST_ARM_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> !arm); // R3
endmodule

// File: rtl/wen_enable_reg.sv
module wen_enable_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic set_req,
    input  logic clr_req,
    output logic en
);
    typedef struct packed {
        logic en;
    } er_state_t;

    er_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr_req)              s_d.en = 1'b0;
        else if (set_req && arm)  s_d.en = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{en: 1'b0};
        else        s_q <= s_d;
    end

    assign en = s_q.en;

    AST_RISE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !(arm && set_req)) |=> !en); // R3
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> !en); // R7
endmodule

// File: rtl/unlock_wen_gate.sv
module unlock_wen_gate #(
    parameter int            DATA_W = 8,
    parameter logic [DATA_W-1:0] KEY_A = 8'h55,
    parameter logic [DATA_W-1:0] KEY_B = 8'hAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              unlk_wr,
    input  logic [DATA_W-1:0] unlk_data,
    input  logic              wen_set,
    input  logic              wen_clr,
    input  logic              fld_wr_req,
    output logic              wr_permit,
    output logic              fld_wr_gnt
);
    logic key_done;
    logic arm;
    logic en;

    wen_key_detect #(.DATA_W(DATA_W), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_det (
        .clk(clk), .rst_n(rst_n), .wr(unlk_wr), .data(unlk_data), .key_done(key_done)
    );

    wen_arm_window u_win (
        .clk(clk), .rst_n(rst_n), .key_done(key_done), .arm(arm)
    );

    wen_enable_reg u_en (
        .clk(clk), .rst_n(rst_n), .arm(arm), .set_req(wen_set),
        .clr_req(wen_clr), .en(en)
    );

    assign wr_permit  = en;
    assign fld_wr_gnt = fld_wr_req & en;

    AST_GNT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        fld_wr_gnt |-> wr_permit); // R8
    AST_CLR_NO_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        wen_clr |=> !wr_permit); // R6
    AST_RISE_NEEDS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_permit) |-> $past(wen_set)); // R2
endmodule

// File: tb/unlock_wen_gate_bench.sv
module unlock_wen_gate_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       unlk_wr = 1'b0;
    logic [7:0] unlk_data = 8'h00;
    logic       wen_set = 1'b0;
    logic       wen_clr = 1'b0;
    logic       fld_wr_req = 1'b0;
    logic       wr_permit;
    logic       fld_wr_gnt;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic  exp_en;
        logic  exp_gnt;
        string tag;
    } exp_t;
    exp_t sbq[$];

    // independent model of the requirements
    logic m_first = 1'b0;
    logic m_arm   = 1'b0;
    logic m_en    = 1'b0;

    always #5 clk = ~clk;

    unlock_wen_gate u_unlock_wen_gate (
        .clk(clk), .rst_n(rst_n), .unlk_wr(unlk_wr), .unlk_data(unlk_data),
        .wen_set(wen_set), .wen_clr(wen_clr), .fld_wr_req(fld_wr_req),
        .wr_permit(wr_permit), .fld_wr_gnt(fld_wr_gnt)
    );

    task automatic step(input logic wr, input logic [7:0] d, input logic st,
                        input logic cl, input logic rq, input string tag);
        logic na;
        @(negedge clk);
        unlk_wr = wr; unlk_data = d; wen_set = st; wen_clr = cl; fld_wr_req = rq;
        @(posedge clk);
        if (cl)              m_en = 1'b0;
        else if (st && m_arm) m_en = 1'b1;
        na = wr && m_first && (d == 8'hAA);
        if (wr) m_first = (d == 8'h55);
        m_arm = na;
        sbq.push_back('{exp_en: m_en, exp_gnt: rq & m_en, tag: tag});
    endtask

    task automatic idle(input string tag);
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, tag);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            if (sbq.size() != 0) begin
                e = sbq.pop_front();
                checks++;
                if (wr_permit !== e.exp_en || fld_wr_gnt !== e.exp_gnt) begin
                    errors++;
                    $display("FAIL %s: permit=%0b gnt=%0b expected permit=%0b gnt=%0b",
                             e.tag, wr_permit, fld_wr_gnt, e.exp_en, e.exp_gnt);
                end
            end
        end
    end

    initial begin : watchdog
        #100000;
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : driver
        #12;
        checks++;
        if (wr_permit !== 1'b0) begin
            errors++;
            $display("FAIL R1: permit=%0b expected 0 in reset", wr_permit);
        end
        @(negedge clk); rst_n = 1'b1;
        // R1: set with no key after reset
        step(1'b0, 8'h00, 1'b1, 1'b0, 1'b1, "R1");
        // R2 and R8: correct key then set in window, grant follows
        step(1'b1, 8'h55, 1'b0, 1'b0, 1'b0, "R2");
        step(1'b1, 8'hAA, 1'b0, 1'b0, 1'b0, "R2");
        step(1'b0, 8'h00, 1'b1, 1'b0, 1'b1, "R2");
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, "R8");
        // R6: clear with no key
        step(1'b0, 8'h00, 1'b0, 1'b1, 1'b1, "R6");
        // R3: set one cycle late
        step(1'b1, 8'h55, 1'b0, 1'b0, 1'b0, "R3");
        step(1'b1, 8'hAA, 1'b0, 1'b0, 1'b0, "R3");
        idle("R3");
        step(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, "R3");
        // R3: set in the same cycle as KEY_B
        step(1'b1, 8'h55, 1'b0, 1'b0, 1'b0, "R3");
        step(1'b1, 8'hAA, 1'b1, 1'b0, 1'b0, "R3");
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, "R3");
        // R4: wrong byte between key bytes
        step(1'b1, 8'h55, 1'b0, 1'b0, 1'b0, "R4");
        step(1'b1, 8'h12, 1'b0, 1'b0, 1'b0, "R4");
        step(1'b1, 8'hAA, 1'b0, 1'b0, 1'b0, "R4");
        step(1'b0, 8'h00, 1'b1, 1'b0, 1'b1, "R4");
        // R5: idle cycles between key bytes
        step(1'b1, 8'h55, 1'b0, 1'b0, 1'b0, "R5");
        idle("R5");
        idle("R5");
        step(1'b1, 8'hAA, 1'b0, 1'b0, 1'b0, "R5");
        step(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, "R5");
        step(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, "R6");
        // R9: repeated KEY_A
        step(1'b1, 8'h55, 1'b0, 1'b0, 1'b0, "R9");
        step(1'b1, 8'h55, 1'b0, 1'b0, 1'b0, "R9");
        step(1'b1, 8'hAA, 1'b0, 1'b0, 1'b0, "R9");
        step(1'b0, 8'h00, 1'b1, 1'b0, 1'b1, "R9");
        step(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, "R6");
        // R7: clear wins over valid set
        step(1'b1, 8'h55, 1'b0, 1'b0, 1'b0, "R7");
        step(1'b1, 8'hAA, 1'b0, 1'b0, 1'b0, "R7");
        step(1'b0, 8'h00, 1'b1, 1'b1, 1'b1, "R7");
        // R8: request while disabled
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, "R8");
        idle("R8");
        @(posedge clk); #3;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule